// File: doc/BRIEF.md
# Transmit Mailbox Abort Controller

This block keeps the 4-bit control code and the interrupt flag of a small set of CAN transmit mailboxes. It lets the CPU cancel a queued transmission safely. A CPU code write to a mailbox that the serializer has not taken takes effect at once. A write to a mailbox that sits in the single serial staging slot, whether it is staged or on the wire, is blocked, so the code keeps its old value.

When the global abort enable is set, a blocked abort request (code 1001) is held as a pending abort. The serializer's later events decide the outcome. A successful send makes the code 1000. An arbitration loss, a transmit error or entry into freeze completes the abort and makes the code 1001. Both outcomes raise the mailbox interrupt flag, and the CPU reads the code after the flag rises to learn which outcome occurred.

The CAN bit engine is not part of the block. Pulses stand in for it: one that stages a mailbox, and one each for a successful send, a lost arbitration and a transmit error. A freeze level input stands in for freeze mode.

Top module: `mb_abort_ctrl`

## Requirements
- R1: After reset, every mailbox code is 1000 (inactive), and all interrupt flags, busy bits and pending-abort bits are 0.
- R2: A CPU write to a mailbox that is not in flight stores the written code on the next cycle. With abort disabled, or when the mailbox code is not 1100 (transmit request), a written 1001 is stored as a plain code and the flag stays 0.
- R3: A staging request makes the addressed mailbox busy on the next cycle only if three conditions hold: the mailbox code is 1100, the staging slot is empty and freeze is low. Otherwise the request is ignored. Staging takes precedence over a CPU write to the same mailbox in the same cycle, so that write is treated as a write to an in-flight mailbox.
- R4: A CPU write to an in-flight mailbox leaves its code unchanged. If abort is enabled and the written code is 1001, the pending-abort bit of that mailbox is set.
- R5: With abort enabled, writing 1001 to a mailbox whose code is 1100 and that is not in flight sets the code to 1001 and raises its flag on the next cycle.
- R6: A successful-send pulse while a mailbox is in flight makes its code 1000, raises its flag, and clears its busy and pending-abort bits, even if an abort was pending.
- R7: An arbitration-loss pulse, an error pulse or a rising edge of freeze frees the staging slot. If an abort was pending, the code becomes 1001 and the flag rises. If no abort was pending, the code stays 1100 and the flag stays 0.
- R8: When a successful-send pulse arrives in the same cycle as a loss or error pulse, the successful send decides the outcome.
- R9: A staging request while freeze is high is ignored.
- R10: Writing 1 to a flag-clear bit clears that flag on the next cycle. When the flag is set and cleared in the same cycle, the set wins.
- R11: With abort disabled, a 1001 write to an in-flight mailbox is blocked and no abort is latched, so a later loss leaves the code at 1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| abort_en_i | input | 1 | Global abort enable |
| freeze_i | input | 1 | Freeze mode level |
| wr_en_i | input | 1 | CPU code write strobe |
| wr_idx_i | input | IDX_W | Mailbox addressed by the write |
| wr_code_i | input | 4 | Code being written |
| flag_clr_i | input | NUM_MB | Write-1-to-clear of interrupt flags |
| load_req_i | input | 1 | Serializer staging request |
| load_idx_i | input | IDX_W | Mailbox to stage |
| tx_ok_i | input | 1 | Staged frame sent successfully |
| arb_lost_i | input | 1 | Staged frame lost arbitration |
| tx_err_i | input | 1 | Error on staged frame |
| mb_code_o | output | 4*NUM_MB | Mailbox codes, mailbox m at bits 4m+3..4m |
| mb_flag_o | output | NUM_MB | Mailbox interrupt flags |
| mb_busy_o | output | NUM_MB | Mailbox sits in the staging slot |
| abort_pend_o | output | NUM_MB | Latched abort awaiting resolution |

## Verification
Every result is registered once. A code, flag, busy or pending-abort bit therefore changes on the first rising edge after the stimulus that causes it, whether the stimulus is a write, a staging request, a serializer pulse or a freeze edge. The bench changes inputs on the falling edge, holds each pulse for exactly one rising edge, and compares the outputs on the next falling edge, one cycle after the stimulus. Blocked writes and ignored staging requests are checked in that same cycle through the unchanged code, busy and pending-abort outputs.

// File: rtl/mb_abort_pkg.sv
// Package: shared code type and the mailbox code values used by the abort controller.
package mb_abort_pkg;
    typedef logic [3:0] code_t;
    localparam code_t CODE_INACTIVE = 4'b1000;
    localparam code_t CODE_TXREQ    = 4'b1100;
    localparam code_t CODE_ABORT    = 4'b1001;
endpackage

// File: rtl/mb_wr_decode.sv
// Module: mb_wr_decode
// Turns the CPU write strobe and mailbox index into one-hot per-mailbox hits.
// Assumes: indices at or above NUM_MB select nothing.
module mb_wr_decode #(
    parameter int NUM_MB = 4,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    output logic [NUM_MB-1:0] wr_hit
);
    for (genvar m = 0; m < NUM_MB; m++) begin : g_hit
        // Purpose: raise the hit of the addressed mailbox.
        assign wr_hit[m] = wr_en && (wr_idx == IDX_W'(m));
    end
endmodule

// File: rtl/mb_serial_track.sv
// Module: mb_serial_track
// Tracks the single serial staging slot: which mailbox it holds and how the
// serializer events resolve it. Emits one-hot grant, sent and drop pulses.
// Assumes: one staged frame at a time; a success outranks loss, error and freeze.
module mb_serial_track #(
    parameter int NUM_MB = 4,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              freeze_i,
    input  logic              load_req,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic [NUM_MB-1:0] txreq_vec,
    input  logic              tx_ok,
    input  logic              arb_lost,
    input  logic              tx_err,
    output logic [NUM_MB-1:0] busy_q,
    output logic [NUM_MB-1:0] grant,
    output logic [NUM_MB-1:0] sent,
    output logic [NUM_MB-1:0] drop
);
    logic             vld_q;
    logic [IDX_W-1:0] idx_q;
    logic             frz_q;
    logic             freeze_rise;
    logic             load_open;
    logic             load_ok;
    logic             ok_ev;
    logic             drop_ev;

    // Purpose: remember the previous freeze level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) frz_q <= 1'b0;
        else        frz_q <= freeze_i;
    end

    assign freeze_rise = freeze_i && !frz_q;
    assign load_open   = load_req && !vld_q && !freeze_i;
    assign ok_ev       = vld_q && tx_ok;
    assign drop_ev     = vld_q && !tx_ok && (arb_lost || tx_err || freeze_rise);

    for (genvar m = 0; m < NUM_MB; m++) begin : g_slot
        // Purpose: per-mailbox view of the staging slot and its events.
        assign grant[m]  = load_open && (load_idx == IDX_W'(m)) && txreq_vec[m];
        assign busy_q[m] = vld_q && (idx_q == IDX_W'(m));
        assign sent[m]   = ok_ev && (idx_q == IDX_W'(m));
        assign drop[m]   = drop_ev && (idx_q == IDX_W'(m));
    end

    assign load_ok = |grant;

    // Purpose: fill the slot on a granted stage, empty it on any resolution.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            idx_q <= '0;
        end else if (ok_ev || drop_ev) begin
            vld_q <= 1'b0;
        end else if (load_ok) begin
            vld_q <= 1'b1;
            idx_q <= load_idx;
        end
    end

    p_single_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_q));

    p_no_stage_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_i && !vld_q) |=> !vld_q);

    p_resolve_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && (tx_ok || arb_lost || tx_err)) |=> !vld_q);
endmodule

// File: rtl/mb_slot.sv
// Module: mb_slot
// Holds one mailbox's code, interrupt flag and pending-abort latch, and
// applies CPU writes and serializer outcomes in priority order:
// sent, then drop, then CPU write.
// Assumes: sent and drop only pulse while the mailbox sits in the staging slot.
module mb_slot
    import mb_abort_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  abort_en,
    input  logic  wr_hit,
    input  code_t wr_code,
    input  logic  busy_q,
    input  logic  grant,
    input  logic  sent,
    input  logic  drop,
    input  logic  flag_clr,
    output code_t code_o,
    output logic  flag_o,
    output logic  pend_o
);
    code_t code_q, code_d;
    logic  flag_q;
    logic  pend_q, pend_d;
    logic  set_flag;
    logic  inflight;
    logic  is_abort_wr;

    assign inflight    = busy_q || grant;
    assign is_abort_wr = abort_en && (wr_code == CODE_ABORT);

    // Purpose: next code, pending latch and flag set from the highest-priority event.
    always_comb begin
        code_d   = code_q;
        pend_d   = pend_q;
        set_flag = 1'b0;
        if (sent) begin
            code_d   = CODE_INACTIVE;
            pend_d   = 1'b0;
            set_flag = 1'b1;
        end else if (drop) begin
            if (pend_q) begin
                code_d   = CODE_ABORT;
                set_flag = 1'b1;
            end
            pend_d = 1'b0;
        end else if (wr_hit) begin
            if (inflight) begin
                if (is_abort_wr) pend_d = 1'b1;
            end else if (is_abort_wr && code_q == CODE_TXREQ) begin
                code_d   = CODE_ABORT;
                set_flag = 1'b1;
            end else begin
                code_d = wr_code;
            end
        end
    end

    // Purpose: register code and pending latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_INACTIVE;
            pend_q <= 1'b0;
        end else begin
            code_q <= code_d;
            pend_q <= pend_d;
        end
    end

    // Purpose: interrupt flag, set wins over write-1-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q && !flag_clr) || set_flag;
    end

    assign code_o = code_q;
    assign flag_o = flag_q;
    assign pend_o = pend_q;

    p_blocked_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && inflight && !sent && !drop) |=> $stable(code_q));

    p_pend_needs_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pend_q |-> busy_q);

    p_immediate_abort_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !inflight && is_abort_wr && code_q == CODE_TXREQ)
        |=> (code_q == CODE_ABORT && flag_q));

    p_sent_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sent |=> (code_q == CODE_INACTIVE && flag_q && !pend_q));

    p_abort_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && pend_q) |=> (code_q == CODE_ABORT && flag_q && !pend_q));

    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && flag_clr && !sent && !drop && !wr_hit) |=> !flag_q);
endmodule

// File: rtl/mb_abort_ctrl.sv
// Module: mb_abort_ctrl (top)
// Transmit mailbox abort controller: per-mailbox code/flag slots, a CPU
// write decoder and the serial staging slot tracker.
// Assumes: CAN bit engine outside; its events arrive as single-cycle pulses.
module mb_abort_ctrl
    import mb_abort_pkg::*;
#(
    parameter int NUM_MB = 4,
    parameter int IDX_W  = $clog2(NUM_MB)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  abort_en_i,
    input  logic                  freeze_i,
    input  logic                  wr_en_i,
    input  logic [IDX_W-1:0]      wr_idx_i,
    input  logic [3:0]            wr_code_i,
    input  logic [NUM_MB-1:0]     flag_clr_i,
    input  logic                  load_req_i,
    input  logic [IDX_W-1:0]      load_idx_i,
    input  logic                  tx_ok_i,
    input  logic                  arb_lost_i,
    input  logic                  tx_err_i,
    output logic [4*NUM_MB-1:0]   mb_code_o,
    output logic [NUM_MB-1:0]     mb_flag_o,
    output logic [NUM_MB-1:0]     mb_busy_o,
    output logic [NUM_MB-1:0]     abort_pend_o
);
    logic [NUM_MB-1:0] wr_hit;
    logic [NUM_MB-1:0] busy_q;
    logic [NUM_MB-1:0] grant;
    logic [NUM_MB-1:0] sent;
    logic [NUM_MB-1:0] drop;
    logic [NUM_MB-1:0] txreq_vec;
    code_t             code_arr [NUM_MB];

    mb_wr_decode #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_dec (
        .wr_en  (wr_en_i),
        .wr_idx (wr_idx_i),
        .wr_hit (wr_hit)
    );

    mb_serial_track #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .freeze_i  (freeze_i),
        .load_req  (load_req_i),
        .load_idx  (load_idx_i),
        .txreq_vec (txreq_vec),
        .tx_ok     (tx_ok_i),
        .arb_lost  (arb_lost_i),
        .tx_err    (tx_err_i),
        .busy_q    (busy_q),
        .grant     (grant),
        .sent      (sent),
        .drop      (drop)
    );

    for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
        mb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .abort_en (abort_en_i),
            .wr_hit   (wr_hit[m]),
            .wr_code  (wr_code_i),
            .busy_q   (busy_q[m]),
            .grant    (grant[m]),
            .sent     (sent[m]),
            .drop     (drop[m]),
            .flag_clr (flag_clr_i[m]),
            .code_o   (code_arr[m]),
            .flag_o   (mb_flag_o[m]),
            .pend_o   (abort_pend_o[m])
        );
        // Purpose: expose codes and mark mailboxes eligible for staging.
        assign mb_code_o[4*m +: 4] = code_arr[m];
        assign txreq_vec[m]        = (code_arr[m] == CODE_TXREQ);
    end

    assign mb_busy_o = busy_q;

    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (mb_flag_o == '0 && mb_busy_o == '0 && abort_pend_o == '0));
endmodule

// File: tb/tb_mb_abort_ctrl.sv
module tb_mb_abort_ctrl;
    localparam int NUM_MB = 4;
    localparam int IDX_W  = 2;
    localparam logic [3:0] C_INACT = 4'b1000;
    localparam logic [3:0] C_TXREQ = 4'b1100;
    localparam logic [3:0] C_ABORT = 4'b1001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic abort_en_i = 1'b0, freeze_i = 1'b0, wr_en_i = 1'b0;
    logic [IDX_W-1:0] wr_idx_i = '0, load_idx_i = '0;
    logic [3:0] wr_code_i = '0;
    logic [NUM_MB-1:0] flag_clr_i = '0;
    logic load_req_i = 1'b0, tx_ok_i = 1'b0, arb_lost_i = 1'b0, tx_err_i = 1'b0;
    logic [4*NUM_MB-1:0] mb_code_o;
    logic [NUM_MB-1:0] mb_flag_o, mb_busy_o, abort_pend_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    mb_abort_ctrl #(.NUM_MB(NUM_MB)) dut (
        .clk(clk), .rst_n(rst_n), .abort_en_i(abort_en_i), .freeze_i(freeze_i),
        .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_code_i(wr_code_i),
        .flag_clr_i(flag_clr_i), .load_req_i(load_req_i), .load_idx_i(load_idx_i),
        .tx_ok_i(tx_ok_i), .arb_lost_i(arb_lost_i), .tx_err_i(tx_err_i),
        .mb_code_o(mb_code_o), .mb_flag_o(mb_flag_o), .mb_busy_o(mb_busy_o),
        .abort_pend_o(abort_pend_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired act=%0d exp<=5000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] code_of(input int m);
        return mb_code_o[4*m +: 4];
    endfunction

    // One rising edge with the current inputs, then drop all pulses.
    task automatic tick();
        @(negedge clk);
        wr_en_i = 0; load_req_i = 0; tx_ok_i = 0; arb_lost_i = 0; tx_err_i = 0;
        flag_clr_i = '0;
    endtask

    task automatic cpu_wr(input int m, input logic [3:0] c);
        wr_en_i = 1; wr_idx_i = IDX_W'(m); wr_code_i = c; tick();
    endtask

    task automatic stage(input int m);
        load_req_i = 1; load_idx_i = IDX_W'(m); tick();
    endtask

    task automatic clr_all();
        flag_clr_i = '1; tick();
    endtask

    task automatic t_reset();
        for (int m = 0; m < NUM_MB; m++) check("R1 code", code_of(m), C_INACT);
        check("R1 flags", mb_flag_o, 0);
        check("R1 busy", mb_busy_o, 0);
        check("R1 pend", abort_pend_o, 0);
    endtask

    task automatic t_plain_write();
        abort_en_i = 0;
        cpu_wr(1, C_TXREQ);
        check("R2 code1", code_of(1), C_TXREQ);
        cpu_wr(2, C_ABORT);
        check("R2 disabled 1001 code", code_of(2), C_ABORT);
        check("R2 disabled 1001 flag", mb_flag_o[2], 0);
        abort_en_i = 1;
        cpu_wr(3, C_ABORT);
        check("R2 idle 1001 code", code_of(3), C_ABORT);
        check("R2 idle 1001 flag", mb_flag_o[3], 0);
        cpu_wr(2, C_INACT);
        cpu_wr(3, C_INACT);
    endtask

    task automatic t_stage_rules();
        stage(0);
        check("R3 stage inactive ignored", mb_busy_o, 0);
        stage(1);
        check("R3 stage granted", mb_busy_o, 4'b0010);
        cpu_wr(2, C_TXREQ);
        stage(2);
        check("R3 slot full ignored", mb_busy_o, 4'b0010);
        tx_ok_i = 1; tick();
        check("R6 sent code", code_of(1), C_INACT);
        check("R6 sent flag", mb_flag_o[1], 1);
        check("R6 busy cleared", mb_busy_o, 0);
        flag_clr_i = 4'b0010; tick();
        check("R10 flag cleared", mb_flag_o[1], 0);
    endtask

    task automatic t_immediate();
        abort_en_i = 1;
        cpu_wr(2, C_ABORT);
        check("R5 code", code_of(2), C_ABORT);
        check("R5 flag", mb_flag_o[2], 1);
        check("R5 not busy", mb_busy_o[2], 0);
        clr_all();
    endtask

    task automatic t_blocked_lost();
        cpu_wr(0, C_TXREQ);
        stage(0);
        cpu_wr(0, C_INACT);
        check("R4 blocked code", code_of(0), C_TXREQ);
        check("R4 no pend", abort_pend_o[0], 0);
        cpu_wr(0, C_ABORT);
        check("R4 abort latched", abort_pend_o[0], 1);
        check("R4 code kept", code_of(0), C_TXREQ);
        check("R4 no flag yet", mb_flag_o[0], 0);
        arb_lost_i = 1; tick();
        check("R7 lost aborts code", code_of(0), C_ABORT);
        check("R7 lost flag", mb_flag_o[0], 1);
        check("R7 pend cleared", abort_pend_o[0], 0);
        check("R7 slot freed", mb_busy_o, 0);
        clr_all();
    endtask

    task automatic t_abort_too_late();
        cpu_wr(1, C_TXREQ);
        stage(1);
        cpu_wr(1, C_ABORT);
        tx_ok_i = 1; tick();
        check("R6 sent despite abort code", code_of(1), C_INACT);
        check("R6 flag", mb_flag_o[1], 1);
        check("R6 pend cleared", abort_pend_o[1], 0);
        clr_all();
    endtask

    task automatic t_err_no_pend();
        cpu_wr(0, C_TXREQ);
        stage(0);
        tx_err_i = 1; tick();
        check("R7 err keeps txreq", code_of(0), C_TXREQ);
        check("R7 err no flag", mb_flag_o[0], 0);
        check("R7 err slot freed", mb_busy_o, 0);
    endtask

    task automatic t_freeze();
        stage(0);
        cpu_wr(0, C_ABORT);
        freeze_i = 1; tick();
        check("R7 freeze aborts", code_of(0), C_ABORT);
        check("R7 freeze flag", mb_flag_o[0], 1);
        cpu_wr(1, C_TXREQ);
        stage(1);
        check("R9 stage in freeze ignored", mb_busy_o, 0);
        freeze_i = 0; tick();
        stage(1);
        check("R9 stage after freeze", mb_busy_o, 4'b0010);
        clr_all();
    endtask

    task automatic t_priority();
        cpu_wr(1, C_ABORT);
        check("R4 pend mb1", abort_pend_o[1], 1);
        tx_ok_i = 1; arb_lost_i = 1; tick();
        check("R8 success wins code", code_of(1), C_INACT);
        check("R8 success wins flag", mb_flag_o[1], 1);
        cpu_wr(1, C_TXREQ);
        stage(1);
        flag_clr_i = 4'b0010;
        tx_ok_i = 1; tick();
        check("R10 set wins over clear", mb_flag_o[1], 1);
        clr_all();
    endtask

    task automatic t_same_cycle();
        cpu_wr(2, C_TXREQ);
        load_req_i = 1; load_idx_i = 2;
        wr_en_i = 1; wr_idx_i = 2; wr_code_i = C_INACT; tick();
        check("R3 stage beats write busy", mb_busy_o, 4'b0100);
        check("R3 stage beats write code", code_of(2), C_TXREQ);
        tx_ok_i = 1; tick();
        clr_all();
    endtask

    task automatic t_disabled_inflight();
        abort_en_i = 0;
        cpu_wr(3, C_TXREQ);
        stage(3);
        cpu_wr(3, C_ABORT);
        check("R11 no latch", abort_pend_o[3], 0);
        check("R11 code kept", code_of(3), C_TXREQ);
        arb_lost_i = 1; tick();
        check("R11 loss leaves txreq", code_of(3), C_TXREQ);
        check("R11 no flag", mb_flag_o[3], 0);
        abort_en_i = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_plain_write();
        t_stage_rules();
        t_immediate();
        t_blocked_lost();
        t_abort_too_late();
        t_err_no_pend();
        t_freeze();
        t_priority();
        t_same_cycle();
        t_disabled_inflight();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule